// File: doc/BRIEF.md
# Dual-Channel Startup Sequencer

This block decides when each of several power channels may begin its start-up. All channels share a single start-up timer. The timer is a cycle counter that sits outside the block. The block watches each channel's ON request and the timer's expiry and low-state indications. It then issues one-cycle start pulses per channel and a one-cycle pulse that launches a new timer period.

In independent mode, the first channel to request starts at once and launches the shared timer. A second request that arrives within a short window of that launch joins the same period and starts immediately, without a new timer launch. A request that arrives later is held. It is released a fixed number of cycles after the running period has expired and the timer has reported its low state. The released start launches a fresh, complete period. A held request is dropped if its ON input falls before it is released. In ganged mode, the channels act as one: all of them start together once every ON input is high.

The window length and the post-timer delay are parameters counted in clock cycles. Defaults correspond to 200 ns and 100 ms at 125 MHz.

Top module: `dual_start_seq`

## Requirements
- R1: While reset is asserted, and after it is released with all ON inputs low, `start_o` and `tmr_start_o` stay low.
- R2: In independent mode, with the sequencer idle and `tmr_low_i` high, a rising ON input on channel c produces a pulse on `start_o[c]` and on `tmr_start_o` in the first cycle after the edge that samples the rise.
- R3: A rise on a channel not yet started in the current period joins that period if it is sampled at most WINDOW_CYC clock edges after the launching edge. The channel pulses `start_o` in the cycle after the sampling edge, and no extra `tmr_start_o` pulse is issued.
- R4: A rise sampled later than the window, while the period is running or the timer has not yet reported low, produces no start pulse and no timer launch at that time. The request is held.
- R5: A held request starts exactly DELAY_CYC clock edges after the edge at which `tmr_low_i` is first sampled high following expiry. Its `start_o` pulse coincides with a new `tmr_start_o` pulse.
- R6: A held request whose ON input (ganged mode: any ON input) falls before release is cancelled. That channel then gets no start pulse, and no start pulse is ever issued for a channel whose request was low on the deciding edge.
- R7: In ganged mode (`indep_mode_i` low), no channel starts while any ON input is low. When the last ON input rises, all channels pulse `start_o` in the same cycle, together with a single `tmr_start_o` pulse.
- R8: Each `start_o` bit and `tmr_start_o` are single-cycle pulses. Each channel starts once per period, and exactly one `tmr_start_o` is issued per timer period.
- R9: A new period is never launched from idle while `tmr_low_i` is low. A request seen then is held and released under the R5 rule once `tmr_low_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| indep_mode_i | input | 1 | 1: channels request independently; 0: ganged |
| on_req_i | input | NUM_CH | Per-channel ON request, level |
| tmr_done_i | input | 1 | Shared timer has expired (pulse or level) |
| tmr_low_i | input | 1 | Shared timer is in its low (idle) state |
| start_o | output | NUM_CH | One-cycle start pulse per channel |
| tmr_start_o | output | 1 | One-cycle pulse launching a timer period |

## Verification
The bench builds the block with NUM_CH=2, WINDOW_CYC=4 and DELAY_CYC=20. A behavioural timer of 10 cycles, plus a 3-cycle fall to low, is driven by `tmr_start_o`. With these short values, a full period, the wait for the low state and the deferred launch fit in under a hundred cycles. Second-channel delays of 0, 1 and exactly WINDOW_CYC edges can therefore be set against WINDOW_CYC+1 and against a rise that lands after expiry. A cancellation inside the deferral, a ganged launch and a launch attempted while the timer is held high are each a short directed case.

// File: rtl/sq_pkg.sv
package sq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE    = 2'd0,
      SQ_RUN     = 2'd1,
      SQ_WAITLOW = 2'd2,
      SQ_DEFER   = 2'd3
   } sq_state_e;
endpackage

// File: rtl/sq_edge_det.sv
module sq_edge_det #(
   parameter int NUM_CH = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] lvl_i,
   output logic [NUM_CH-1:0] rise_o
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic lvl_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) lvl_q <= 1'b0;
         else         lvl_q <= lvl_i[c];
      end
      assign rise_o[c] = lvl_i[c] & ~lvl_q;
   end
endmodule

// File: rtl/sq_req_sel.sv
module sq_req_sel #(
   parameter int NUM_CH = 2
) (
   input  logic              indep_i,
   input  logic [NUM_CH-1:0] on_i,
   output logic [NUM_CH-1:0] lvl_o
);
   logic all_on;
   assign all_on = &on_i;
   for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
      assign lvl_o[c] = indep_i ? on_i[c] : all_on;
   end
endmodule

// File: rtl/sq_down_cnt.sv
module sq_down_cnt #(
   parameter int WIDTH = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   input  logic             en_i,
   output logic             zero_o
);
   logic [WIDTH-1:0] cnt_q;

   if (WIDTH < 1) begin : g_bad_width
      $error("sq_down_cnt: WIDTH must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cnt_q <= '0;
      else if (load_i)               cnt_q <= load_val_i;
      else if (en_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R5
   cnt_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (zero_o && en_i && !load_i) |=> zero_o);
endmodule

// File: rtl/dual_start_seq.sv
module dual_start_seq
   import sq_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int WINDOW_CYC = 25,
   parameter int DELAY_CYC  = 12_500_000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              indep_mode_i,
   input  logic [NUM_CH-1:0] on_req_i,
   input  logic              tmr_done_i,
   input  logic              tmr_low_i,
   output logic [NUM_CH-1:0] start_o,
   output logic              tmr_start_o
);
   localparam int WIN_W = $clog2(WINDOW_CYC + 1);
   localparam int DLY_W = $clog2(DELAY_CYC + 1);
   localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WINDOW_CYC);
   localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(DELAY_CYC - 1);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("dual_start_seq: NUM_CH must be at least 2");
   end
   if (WINDOW_CYC < 1) begin : g_bad_win
      $error("dual_start_seq: WINDOW_CYC must be at least 1");
   end
   if (DELAY_CYC < 1) begin : g_bad_dly
      $error("dual_start_seq: DELAY_CYC must be at least 1");
   end

   logic [NUM_CH-1:0] lvl, rise;
   logic [NUM_CH-1:0] pend_q, pend_d, pend_live;
   logic [NUM_CH-1:0] started_q, started_d;
   logic [NUM_CH-1:0] join_now;
   logic [NUM_CH-1:0] start_d;
   logic              tstart_d;
   logic              win_load, win_zero;
   logic              dly_load, dly_zero, dly_en;
   sq_state_e         state_q, state_d;

   sq_req_sel #(.NUM_CH(NUM_CH)) u_sel (
      .indep_i (indep_mode_i),
      .on_i    (on_req_i),
      .lvl_o   (lvl)
   );

   sq_edge_det #(.NUM_CH(NUM_CH)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl),
      .rise_o (rise)
   );

   sq_down_cnt #(.WIDTH(WIN_W)) u_win (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (win_load),
      .load_val_i (WIN_LOAD),
      .en_i       (1'b1),
      .zero_o     (win_zero)
   );

   assign dly_en = (state_q == SQ_DEFER);

   sq_down_cnt #(.WIDTH(DLY_W)) u_dly (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (dly_load),
      .load_val_i (DLY_LOAD),
      .en_i       (dly_en),
      .zero_o     (dly_zero)
   );

   assign pend_live = pend_q & lvl;
   assign join_now  = win_zero ? '0 : (rise & ~started_q);

   always_comb begin
      state_d   = state_q;
      pend_d    = pend_live;
      started_d = started_q;
      start_d   = '0;
      tstart_d  = 1'b0;
      win_load  = 1'b0;
      dly_load  = 1'b0;
      unique case (state_q)
         SQ_IDLE: begin
            if (|rise) begin
               if (tmr_low_i) begin
                  start_d   = rise;
                  tstart_d  = 1'b1;
                  started_d = rise;
                  win_load  = 1'b1;
                  state_d   = SQ_RUN;
               end else begin
                  pend_d  = pend_live | rise;
                  state_d = SQ_WAITLOW;
               end
            end
         end
         SQ_RUN: begin
            start_d   = join_now;
            started_d = started_q | join_now;
            pend_d    = pend_live | (rise & ~join_now);
            if (tmr_done_i) state_d = SQ_WAITLOW;
         end
         SQ_WAITLOW: begin
            pend_d = pend_live | rise;
            if (tmr_low_i) begin
               if (|pend_d) begin
                  state_d  = SQ_DEFER;
                  dly_load = 1'b1;
               end else begin
                  state_d = SQ_IDLE;
               end
            end
         end
         SQ_DEFER: begin
            pend_d = pend_live | rise;
            if (!(|pend_d)) begin
               state_d = SQ_IDLE;
            end else if (dly_zero) begin
               start_d   = pend_d;
               tstart_d  = 1'b1;
               started_d = pend_d;
               pend_d    = '0;
               win_load  = 1'b1;
               state_d   = SQ_RUN;
            end
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= SQ_IDLE;
         pend_q      <= '0;
         started_q   <= '0;
         start_o     <= '0;
         tmr_start_o <= 1'b0;
      end else begin
         state_q     <= state_d;
         pend_q      <= pend_d;
         started_q   <= started_d;
         start_o     <= start_d;
         tmr_start_o <= tstart_d;
      end
   end

   // R8
   tmr_start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr_start_o |=> !tmr_start_o);

   // R8
   start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|start_o) |=> ((start_o & $past(start_o)) == '0));

   // R4
   no_start_waitlow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SQ_WAITLOW) |=> (start_o == '0));

   // R6
   start_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|start_o) |-> ((start_o & ~$past(lvl)) == '0));

   // R3
   join_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|start_o) && !tmr_start_o) |-> ($past(state_q) == SQ_RUN && !$past(win_zero)));

   // R5
   defer_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SQ_DEFER && dly_zero && |(pend_q & lvl)) |=> tmr_start_o);

   // R9
   launch_needs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SQ_IDLE && !tmr_low_i) |=> !tmr_start_o);
endmodule

// File: tb/dual_start_seq_bench.sv
module dual_start_seq_bench;
   localparam int W    = 4;
   localparam int D    = 20;
   localparam int TMR  = 10;
   localparam int LOWC = 3;

   // stimulus: first channel, second delay (edges), cancel; expected: joins window
   localparam int NVEC = 6;
   localparam int VEC [NVEC][4] = '{
      '{0, 0,  0, 1},
      '{0, 1,  0, 1},
      '{1, 4,  0, 1},
      '{0, 5,  0, 0},
      '{1, 5,  1, 0},
      '{1, 12, 0, 0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       indep = 1'b1;
   logic [1:0] on_req = 2'b00;
   logic       tmr_done = 1'b0;
   logic       tlow_m = 1'b1;
   logic       hold_low = 1'b0;
   logic       tmr_low;
   logic [1:0] start;
   logic       tmr_start;

   int cyc = 0;
   int checks = 0;
   int failures = 0;
   int tcnt_run = 0, lcnt_run = 0;
   int last_low_cyc = 0;
   int scnt [2];
   int scyc [2];
   int slow [2];
   int tscnt = 0;
   bit done_flag = 1'b0;

   assign tmr_low = tlow_m & ~hold_low;

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   dual_start_seq #(.NUM_CH(2), .WINDOW_CYC(W), .DELAY_CYC(D)) u_dual_start_seq (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .indep_mode_i (indep),
      .on_req_i     (on_req),
      .tmr_done_i   (tmr_done),
      .tmr_low_i    (tmr_low),
      .start_o      (start),
      .tmr_start_o  (tmr_start)
   );

   // behavioural shared timer
   always @(negedge clk) begin
      tmr_done <= 1'b0;
      if (!rst_n) begin
         tcnt_run <= 0; lcnt_run <= 0; tlow_m <= 1'b1;
      end else if (tmr_start) begin
         tcnt_run <= TMR; lcnt_run <= 0; tlow_m <= 1'b0;
      end else if (tcnt_run != 0) begin
         tcnt_run <= tcnt_run - 1;
         if (tcnt_run == 1) begin tmr_done <= 1'b1; lcnt_run <= LOWC; end
      end else if (lcnt_run != 0) begin
         lcnt_run <= lcnt_run - 1;
         if (lcnt_run == 1) begin tlow_m <= 1'b1; last_low_cyc <= cyc; end
      end
   end

   // output monitor
   initial begin scnt = '{0, 0}; scyc = '{0, 0}; slow = '{0, 0}; end
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < 2; c++) begin
            if (start[c]) begin
               scnt[c] <= scnt[c] + 1;
               scyc[c] <= cyc;
               slow[c] <= last_low_cyc;
            end
         end
         if (tmr_start) tscnt <= tscnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_case(input int first, input int d, input int cancel, input int joins);
      int sec = 1 - first;
      int k, b_f, b_s, b_t;
      @(negedge clk);
      k = cyc; b_f = scnt[first]; b_s = scnt[sec]; b_t = tscnt;
      on_req[first] = 1'b1;
      if (d == 0) on_req[sec] = 1'b1;
      repeat (d) @(negedge clk);
      if (d > 0) on_req[sec] = 1'b1;
      if (cancel != 0) begin
         repeat (3) @(negedge clk);
         on_req[sec] = 1'b0;
      end
      repeat (80) @(negedge clk);
      chk(scnt[first] - b_f == 1, "R2 first start count", scnt[first] - b_f, 1);
      chk(scyc[first] == k + 1, "R2 first start cycle", scyc[first], k + 1);
      if (joins != 0) begin
         chk(scnt[sec] - b_s == 1, "R3 joined start count", scnt[sec] - b_s, 1);
         chk(scyc[sec] == k + d + 1, "R3 joined start cycle", scyc[sec], k + d + 1);
         chk(tscnt - b_t == 1, "R8 one timer launch", tscnt - b_t, 1);
      end else if (cancel != 0) begin
         chk(scnt[sec] == b_s, "R6 cancelled start count", scnt[sec] - b_s, 0);
         chk(tscnt - b_t == 1, "R6 timer launches", tscnt - b_t, 1);
      end else begin
         chk(scnt[sec] - b_s == 1, "R4 deferred start count", scnt[sec] - b_s, 1);
         chk(scyc[sec] == slow[sec] + 1 + D, "R5 deferred start cycle", scyc[sec],
             slow[sec] + 1 + D);
         chk(tscnt - b_t == 2, "R5 second timer launch", tscnt - b_t, 2);
      end
      on_req = 2'b00;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      int k, b0, b1, bt, n;
      repeat (3) @(negedge clk);
      chk(start == 2'b00 && !tmr_start, "R1 outputs in reset", {start, tmr_start}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(start == 2'b00 && !tmr_start && tscnt == 0, "R1 outputs after reset",
          {start, tmr_start}, 0);

      for (int i = 0; i < NVEC; i++)
         run_case(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

      // R7 ganged mode
      indep = 1'b0;
      @(negedge clk);
      b0 = scnt[0]; b1 = scnt[1]; bt = tscnt;
      on_req[0] = 1'b1;
      repeat (8) @(negedge clk);
      chk(scnt[0] == b0 && scnt[1] == b1 && tscnt == bt, "R7 no start with one ON",
          scnt[0] + scnt[1] - b0 - b1, 0);
      k = cyc;
      on_req[1] = 1'b1;
      repeat (40) @(negedge clk);
      chk(scnt[0] - b0 == 1 && scnt[1] - b1 == 1, "R7 both start once",
          scnt[0] + scnt[1] - b0 - b1, 2);
      chk(scyc[0] == k + 1 && scyc[1] == k + 1, "R7 same start cycle", scyc[1], k + 1);
      chk(tscnt - bt == 1, "R7 single timer launch", tscnt - bt, 1);
      on_req = 2'b00;
      indep = 1'b1;
      repeat (5) @(negedge clk);

      // R9 launch attempted while timer not low
      hold_low = 1'b1;
      @(negedge clk);
      b0 = scnt[0]; bt = tscnt;
      on_req[0] = 1'b1;
      repeat (6) @(negedge clk);
      chk(scnt[0] == b0 && tscnt == bt, "R9 no launch while timer high", scnt[0] - b0, 0);
      n = cyc;
      hold_low = 1'b0;
      repeat (D + 10) @(negedge clk);
      chk(scnt[0] - b0 == 1, "R9 held start released", scnt[0] - b0, 1);
      chk(scyc[0] == n + 1 + D, "R9 release cycle", scyc[0], n + 1 + D);
      on_req = 2'b00;
      repeat (30) @(negedge clk);

      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule